// File: doc/BRIEF.md
# Serial Control Register Interface

This block is a write-only, three-wire serial port that sets the control state of an imaging front end. A host shifts a 16-bit command word in on a serial clock and then raises a load strobe. The word is kept in a holding latch, and its load event is carried into the conversion clock domain. There it is decoded and written into one of four control registers: the operating mode (standby flag), a 10-bit gain code, a 4-bit black clamp level code and three strobe polarity bits.

The word carries a test flag in bit 15, a 3-bit register address in bits 14:12 and a 12-bit operand in bits 11:0. Words with the test flag set, or with an address of 4 or above, are dropped. An asynchronous active-low reset puts every register at its default value. The block also drives a decoded clamp level on a 12-bit scale, computed as 2 + 16 × code.

Top module: `ser_ctrl_regs`

## Requirements
- R1: While `rst_n` is low, and asynchronously to both clocks, the outputs take their defaults: `standby`=0, `gain_code`=128, `clamp_code`=8, `clamp_level`=130, all three polarity outputs 0. The serial shift register is cleared to zero.
- R2: A bit on `ser_data` enters the shift register on a rising `ser_clk` edge only while `ser_load` is low. Edges while `ser_load` is high are ignored. The word is sent least significant bit first, so the first of 16 bits becomes bit 0. Bit 15 is the test flag, bits 14:12 the address and bits 11:0 the operand.
- R3: The word latched on a rising edge of `ser_load` is the last 16 bits shifted in since reset, whatever the frame length. In a longer frame the earlier bits are lost. In a shorter frame the older bits that remain are kept.
- R4: The addressed register changes on the fifth rising `clk` edge after the `ser_load` rising edge, when that edge falls mid-period. It keeps its old value through the fourth edge.
- R5: Address 0 writes operand bit 0 to `standby` (1 = standby).
- R6: Address 1 writes operand bits 9:0 to `gain_code`.
- R7: Address 2 writes operand bits 3:0 to `clamp_code`, and `clamp_level` equals 2 + 16 × `clamp_code`.
- R8: Address 3 writes operand bit 0 to `pol_dummy`, bit 1 to `pol_black` and bit 2 to `pol_sample` (0 = active low, 1 = active high).
- R9: A word with an address of 4 to 7, or with the test flag (bit 15) set, changes no register.
- R10: While `standby` is 1, the serial port and all registers still accept writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; the registers update on it |
| rst_n | input | 1 | Asynchronous active-low reset to defaults |
| ser_clk | input | 1 | Serial shift clock, rising edge |
| ser_load | input | 1 | Low to shift; its rising edge latches the word |
| ser_data | input | 1 | Serial data, least significant bit first |
| standby | output | 1 | Operating mode flag, 1 = standby |
| gain_code | output | 10 | Gain control code |
| clamp_code | output | 4 | Black clamp level code |
| clamp_level | output | 12 | Decoded clamp level, 2 + 16 × code |
| pol_dummy | output | 1 | Dummy clamp strobe polarity |
| pol_black | output | 1 | Black clamp strobe polarity |
| pol_sample | output | 1 | Sample strobes polarity |

## Verification
The bench builds the block with its default parameters: a 16-bit word and a two-stage synchronizer. With this word size the bench can write every one of the 1024 gain codes and every clamp and polarity code, and it checks each write one edge before and exactly at the expected update edge. Frames of 12, 16 and 20 bits, serial clock edges while the load strobe is high, all four reserved addresses and test-flag words are checked against a model of the last 16 shifted bits. An asynchronous reset in the middle of the run is also checked.

// File: rtl/scr_pkg.sv
// Package: shared widths, address codes, reset defaults and the register type
// for the serial control register interface.
// Assumes a 16-bit command word: flag in the top bit, then address, then operand.
package scr_pkg;
    parameter int WORD_W    = 16;
    parameter int ADDR_W    = 3;
    parameter int DATA_W    = 12;
    parameter int GAIN_W    = 10;
    parameter int CLAMP_W   = 4;
    parameter int POL_W     = 3;
    parameter int LEVEL_W   = 12;
    parameter int LVL_SHIFT = 4;
    parameter int LVL_BASE  = 2;
    parameter int NUM_REGS  = 4;

    localparam int FLAG_BIT = WORD_W - 1;
    localparam int ADDR_LSB = DATA_W;

    typedef enum logic [ADDR_W-1:0] {
        ADR_MODE  = 3'd0,
        ADR_GAIN  = 3'd1,
        ADR_CLAMP = 3'd2,
        ADR_POL   = 3'd3
    } reg_addr_e;

    typedef struct packed {
        logic               standby;
        logic [GAIN_W-1:0]  gain;
        logic [CLAMP_W-1:0] clamp;
        logic [POL_W-1:0]   pol;
    } ctrl_regs_t;

    localparam ctrl_regs_t REGS_DEFAULT = '{
        standby: 1'b0,
        gain:    GAIN_W'(128),
        clamp:   CLAMP_W'(8),
        pol:     POL_W'(0)
    };
endpackage

// File: rtl/scr_shift_capture.sv
// Module: serial-clock side. It shifts bits in least significant bit first
// while the load strobe is low. On the rising load edge it copies the shift
// register into a holding latch and flips a toggle that announces a new word.
// Assumes: the latch stays stable until the next load edge, which the host
// spaces far enough apart for the conversion domain to consume each word.
module scr_shift_capture
    import scr_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         rst_n,
    input  logic         ser_clk,
    input  logic         ser_load,
    input  logic         ser_data,
    output logic [W-1:0] word_q,
    output logic         toggle_q
);
    logic [W-1:0] shift_q;

    // Shift register: new bit enters at the top, so the oldest kept bit ends at bit 0.
    always_ff @(posedge ser_clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (!ser_load) begin
            shift_q <= {ser_data, shift_q[W-1:1]};
        end
    end

    // Holding latch and announce toggle, both clocked by the load strobe.
    always_ff @(posedge ser_load or negedge rst_n) begin
        if (!rst_n) begin
            word_q   <= '0;
            toggle_q <= 1'b0;
        end else begin
            word_q   <= shift_q;
            toggle_q <= ~toggle_q;
        end
    end
endmodule

// File: rtl/scr_load_sync.sv
// Module: brings the load toggle into the conversion clock domain through a
// chain of synchronizer flops and turns each toggle change into a one-cycle pulse.
// Assumes: toggle changes are spaced by more than SYNC_STAGES + 2 clock cycles.
module scr_load_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle_in,
    output logic load_pulse
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    // Synchronizer chain plus one history flop for the edge detector.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], toggle_in};
        end
    end

    // Edge detect: the last synchronized value differs from the one seen before it.
    assign load_pulse = chain_q[CHAIN_W-1] ^ chain_q[CHAIN_W-2];

    // R4: one load event gives exactly one pulse.
    assert_one_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> !load_pulse);
endmodule

// File: rtl/scr_reg_bank.sv
// Module: conversion-domain side. It captures the latched word on the load
// pulse, decodes flag and address in a second stage, and updates the addressed
// register in a third. Words with the flag set or a reserved address select nothing.
// Assumes: word_in has been stable for at least two clock cycles when load_pulse rises.
module scr_reg_bank
    import scr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_pulse,
    input  logic [WORD_W-1:0] word_in,
    output ctrl_regs_t        regs_q
);
    logic                cap_valid;
    logic [WORD_W-1:0]   cap_word;
    logic                upd_valid;
    logic [NUM_REGS-1:0] upd_sel;
    logic [DATA_W-1:0]   upd_data;
    logic [NUM_REGS-1:0] sel_next;
    logic [ADDR_W-1:0]   cap_addr;
    logic                unused_hi;

    assign cap_addr  = cap_word[ADDR_LSB +: ADDR_W];
    assign unused_hi = ^upd_data[DATA_W-1:GAIN_W];

    // Stage 1: take a copy of the held word when its load event arrives.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
            cap_word  <= '0;
        end else begin
            cap_valid <= load_pulse;
            if (load_pulse) begin
                cap_word <= word_in;
            end
        end
    end

    // Address decode: one select per implemented register, none for the flag or reserved codes.
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            sel_next[i] = cap_valid && !cap_word[FLAG_BIT] && (cap_addr == ADDR_W'(i));
        end
    end

    // Stage 2: register the decoded select and the operand.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_valid <= 1'b0;
            upd_sel   <= '0;
            upd_data  <= '0;
        end else begin
            upd_valid <= cap_valid;
            upd_sel   <= sel_next;
            upd_data  <= cap_word[DATA_W-1:0];
        end
    end

    // Stage 3: write the selected register field from the operand.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= REGS_DEFAULT;
        end else begin
            if (upd_sel[ADR_MODE])  regs_q.standby <= upd_data[0];
            if (upd_sel[ADR_GAIN])  regs_q.gain    <= upd_data[GAIN_W-1:0];
            if (upd_sel[ADR_CLAMP]) regs_q.clamp   <= upd_data[CLAMP_W-1:0];
            if (upd_sel[ADR_POL])   regs_q.pol     <= upd_data[POL_W-1:0];
        end
    end

    // R4: registers only move on the cycle after a decoded write.
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(|upd_sel) |=> $stable(regs_q));

    // R4: the update stage only carries a word the capture stage took a cycle earlier.
    assert_stage_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> $past(cap_valid));

    // R9: flagged or reserved words leave every register untouched.
    assert_reserved_no_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && (cap_word[FLAG_BIT] || cap_addr[ADDR_W-1])) |-> ##2 $stable(regs_q));
endmodule

// File: rtl/ser_ctrl_regs.sv
// Module: top of the serial control register interface. It joins the
// serial-side capture, the load synchronizer and the register bank, and
// decodes the clamp level onto its 12-bit scale.
// Assumes: ser_load is high between frames, and successive load edges are
// several conversion clock cycles apart.
module ser_ctrl_regs
    import scr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_load,
    input  logic               ser_data,
    output logic               standby,
    output logic [GAIN_W-1:0]  gain_code,
    output logic [CLAMP_W-1:0] clamp_code,
    output logic [LEVEL_W-1:0] clamp_level,
    output logic               pol_dummy,
    output logic               pol_black,
    output logic               pol_sample
);
    logic [WORD_W-1:0] held_word;
    logic              held_toggle;
    logic              load_pulse;
    ctrl_regs_t        regs;

    scr_shift_capture #(.W(WORD_W)) u_capture (
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_load (ser_load),
        .ser_data (ser_data),
        .word_q   (held_word),
        .toggle_q (held_toggle)
    );

    scr_load_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .toggle_in  (held_toggle),
        .load_pulse (load_pulse)
    );

    scr_reg_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_pulse (load_pulse),
        .word_in    (held_word),
        .regs_q     (regs)
    );

    // Output mapping of the register fields.
    assign standby    = regs.standby;
    assign gain_code  = regs.gain;
    assign clamp_code = regs.clamp;
    assign pol_dummy  = regs.pol[0];
    assign pol_black  = regs.pol[1];
    assign pol_sample = regs.pol[2];

    // Clamp level decode: base offset plus code times the step.
    assign clamp_level = (LEVEL_W'(regs.clamp) << LVL_SHIFT) + LEVEL_W'(LVL_BASE);
endmodule

// File: tb/sim_ser_ctrl_regs.sv
module sim_ser_ctrl_regs;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_load = 1'b1;
    logic ser_data = 1'b0;
    logic        standby;
    logic [9:0]  gain_code;
    logic [3:0]  clamp_code;
    logic [11:0] clamp_level;
    logic        pol_dummy, pol_black, pol_sample;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] hist = '0;
    logic        m_sb = 0;
    logic [9:0]  m_gain = 10'd128;
    logic [3:0]  m_clamp = 4'd8;
    logic [2:0]  m_pol = 3'd0;

    always #2.5 clk = ~clk;

    ser_ctrl_regs u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_load(ser_load),
        .ser_data(ser_data), .standby(standby), .gain_code(gain_code),
        .clamp_code(clamp_code), .clamp_level(clamp_level),
        .pol_dummy(pol_dummy), .pol_black(pol_black), .pol_sample(pol_sample)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic sb, input logic [9:0] g,
                             input logic [3:0] c, input logic [2:0] p);
        check(req, "standby", int'(standby), int'(sb));
        check(req, "gain", int'(gain_code), int'(g));
        check(req, "clamp_code", int'(clamp_code), int'(c));
        check(req, "clamp_level", int'(clamp_level), 2 + 16 * int'(c));
        check(req, "pol_dummy", int'(pol_dummy), int'(p[0]));
        check(req, "pol_black", int'(pol_black), int'(p[1]));
        check(req, "pol_sample", int'(pol_sample), int'(p[2]));
    endtask

    // Shift n bits, bit 0 of bits first; the model keeps the last 16.
    task automatic shift_bits(input logic [31:0] bits, input int n);
        ser_load = 1'b0;
        for (int i = 0; i < n; i++) begin
            ser_data = bits[i];
            #5 ser_clk = 1'b1;
            hist = {bits[i], hist[15:1]};
            #5 ser_clk = 1'b0;
        end
    endtask

    // Raise the load strobe mid-period; check old values through edge 4, new on edge 5.
    task automatic commit(input string req);
        logic        o_sb = m_sb;
        logic [9:0]  o_g = m_gain;
        logic [3:0]  o_c = m_clamp;
        logic [2:0]  o_p = m_pol;
        logic [15:0] w = hist;
        if (!w[15]) begin
            case (w[14:12])
                3'd0: m_sb = w[0];
                3'd1: m_gain = w[9:0];
                3'd2: m_clamp = w[3:0];
                3'd3: m_pol = w[2:0];
                default: ;
            endcase
        end
        @(negedge clk);
        ser_load = 1'b1;
        repeat (4) @(posedge clk);
        #1 check_all("R4", o_sb, o_g, o_c, o_p);
        @(posedge clk);
        #1 check_all(req, m_sb, m_gain, m_clamp, m_pol);
    endtask

    task automatic write_word(input logic [15:0] w, input string req);
        shift_bits({16'h0, w}, 16);
        commit(req);
    endtask

    initial begin
        #900000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #12;
        check_all("R1", 1'b0, 10'd128, 4'd8, 3'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: every gain code
        for (int g = 0; g < 1024; g++) write_word({4'b0001, 2'b00, 10'(g)}, "R6");
        // R7: every clamp code, upper operand bits set
        for (int c = 0; c < 16; c++) write_word({4'b0010, 8'hFF, 4'(c)}, "R7");
        // R8: every polarity combination
        for (int p = 0; p < 8; p++) write_word({4'b0011, 9'h1FF, 3'(p)}, "R8");
        // R5: standby on and off
        write_word(16'h0001, "R5");
        // R10: writes still land while in standby
        write_word({4'b0001, 12'h2A5}, "R10");
        write_word({4'b0011, 12'h005}, "R10");
        write_word(16'h0FFE, "R5");
        // R9: reserved addresses and flagged words
        for (int a = 4; a < 8; a++) write_word({1'b0, 3'(a), 12'hFFF}, "R9");
        write_word({4'b1001, 12'h3FF}, "R9");
        write_word({4'b1000, 12'h001}, "R9");
        write_word({4'b1010, 12'h00F}, "R9");
        // R3: 20-bit frame, last 16 count (gain 0x155)
        shift_bits({12'h0, 16'h1155, 4'hF}, 20);
        commit("R3");
        // R2: ser_clk edges while ser_load is high are ignored
        ser_data = 1'b1;
        repeat (5) begin
            #5 ser_clk = 1'b1;
            #5 ser_clk = 1'b0;
        end
        #1 check_all("R2", m_sb, m_gain, m_clamp, m_pol);
        // R3: 12-bit frame keeps the 4 oldest remaining bits
        write_word({4'b0000, 12'h213}, "R2");
        shift_bits({20'h0, 12'h1C3}, 12);
        commit("R3");
        // R1: asynchronous reset mid-period
        #1.3 rst_n = 1'b0;
        hist = '0;
        m_sb = 0; m_gain = 10'd128; m_clamp = 4'd8; m_pol = 3'd0;
        #0.5 check_all("R1", 1'b0, 10'd128, 4'd8, 3'd0);
        @(negedge clk);
        rst_n = 1'b1;
        shift_bits({20'h0, 12'h037}, 12);
        commit("R1");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule